// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a single display output. Software programs the line and frame geometry, the sync pulse placement and the sync polarities through a small word-addressed register port. The block then runs a pixel counter and a line counter on the pixel clock and drives horizontal sync, vertical sync, a display-enable qualifier, a rectangular active-window flag and the current pixel column and row.

Geometry registers hold two fields each: an upper field at bits [27:16] and a lower field at bits [11:0]. Totals, visible ends and sync starts are written as the index of the pixel or line (count minus one). Sync pulse widths are written as raw counts. Software writes land in a pending bank, which is copied into the working bank only when a frame ends or while timing is stopped, so a frame is never torn. The plane bit is held back further and applies only at the start of the next vertical sync.

Top module: `disp_timing_gen`

## Requirements
- R1: After a synchronous active-low reset all registers read zero, and hsync, vsync, de, win, pix_x and pix_y are all 0.
- R2: Register map (word address on reg_addr): 0 = control {bit4 edge select, bit3 vsync invert, bit2 hsync invert, bit1 plane, bit0 run}; 1 = horizontal {[27:16] line total minus one, [11:0] last visible column}; 2 = hsync {[27:16] width in pixels, [11:0] first sync column}; 3 = vertical {[27:16] frame total minus one, [11:0] last visible row}; 4 = vsync {[27:16] height in lines, [11:0] first sync row}; 5 = window start {[27:16] top row, [11:0] left column}; 6 = window end {[27:16] bottom row, [11:0] right column}. Reads return the pending written value at once, except the plane bit.
- R3: While running, pix_x counts 0 up to the line total field and wraps to 0; pix_y advances by one at each wrap of pix_x and wraps to 0 after the frame total field.
- R4: de is 1 exactly when run and the applied plane are both set, pix_x is at most the last visible column and pix_y is at most the last visible row.
- R5: Before polarity, hsync is 1 for pix_x from the first sync column up to that column plus the width minus one.
- R6: Before polarity, vsync is 1 for pix_y from the first sync row up to that row plus the height minus one, over whole lines.
- R7: A set hsync-invert or vsync-invert bit inverts that sync output, including its idle level.
- R8: With run cleared, pix_x and pix_y stay 0, de and win are 0 and both syncs sit at their inactive level.
- R9: A plane bit write is applied only when the line counter reaches the first sync row at column 0; until then the control readback shows the old plane state.
- R10: Writes to every field except plane take effect at the first pixel of the next frame; the frame in progress keeps its old geometry.
- R11: win is 1 while running when pix_x lies between the left and right columns and pix_y between the top and bottom rows, bounds included.
- R12: With edge select 0 all outputs change just after the rising clock edge; with edge select 1 they are re-timed to the falling edge, so just after a rising edge they still show the previous pixel.

Ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Display enable |
| win | output | 1 | Inside the active window |
| pix_x | output | 12 | Current pixel column |
| pix_y | output | 12 | Current pixel row |

## Verification
Every output is compared on every pixel of whole frames against arithmetic on a small geometry (20 by 10, then 24 by 10), so each column and row boundary of the visible area, the sync pulses and the window is hit from both sides. Mid-frame rewrites of the line total, the sync position, the window and the polarity bits separate a frame-boundary update from an immediate one, since the frame in progress must keep the old line length. A plane toggle written in a visible line, with readbacks before and after the sync row, tells a deferred plane change from an immediate one, and sampling shortly after the rising edge with each edge-select setting tells the two output timings apart.

// File: rtl/dtg_pkg.sv
// Package: register addresses, control bit positions and geometry field
// indices shared by the timing generator modules.
package dtg_pkg;
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_HORZ  = 1;
    localparam int ADDR_HSYNC = 2;
    localparam int ADDR_VERT  = 3;
    localparam int ADDR_VSYNC = 4;
    localparam int ADDR_WTL   = 5;
    localparam int ADDR_WBR   = 6;

    // control word bit positions
    localparam int CTRL_W   = 5;
    localparam int CB_RUN   = 0;
    localparam int CB_PLANE = 1;
    localparam int CB_HINV  = 2;
    localparam int CB_VINV  = 3;
    localparam int CB_EDGE  = 4;

    // geometry fields: register r (1..6) holds field 2(r-1) low, 2(r-1)+1 high
    localparam int NFIELD  = 12;
    localparam int F_HVIS  = 0;
    localparam int F_HTOT  = 1;
    localparam int F_HSS   = 2;
    localparam int F_HSW   = 3;
    localparam int F_VVIS  = 4;
    localparam int F_VTOT  = 5;
    localparam int F_VSS   = 6;
    localparam int F_VSH   = 7;
    localparam int F_WL    = 8;
    localparam int F_WT    = 9;
    localparam int F_WR    = 10;
    localparam int F_WB    = 11;

    localparam int HI_LSB  = 16;
endpackage

// File: rtl/dtg_regs.sv
// Register bank: pending copy written by software, working copy used by the
// counters. Assumes frame_end is a one-cycle strobe on the last pixel of a
// frame and plane_stb a strobe at column 0 of the first sync row.
module dtg_regs
    import dtg_pkg::*;
#(
    parameter int CW = 12,
    parameter int AW = 3,
    parameter int DW = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    input  logic                       frame_end,
    input  logic                       plane_stb,
    output logic [CTRL_W-1:0]          ctrl_a,
    output logic                       plane_a,
    output logic [NFIELD-1:0][CW-1:0]  geo_a
);
    localparam int NREG = NFIELD / 2;

    logic [CTRL_W-1:0]         ctrl_p;
    logic [NFIELD-1:0][CW-1:0] geo_p;
    logic [CTRL_W-1:0]         ctrl_rb;
    logic [DW-1:0]             word [NREG+1];
    logic                      load;
    logic                      wdata_unused;

    assign wdata_unused = ^wdata;
    assign load = frame_end || !ctrl_a[CB_RUN];

    // capture software writes into the pending bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_p <= '0;
            geo_p  <= '0;
        end else if (we) begin
            if (addr == AW'(ADDR_CTRL))
                ctrl_p <= wdata[CTRL_W-1:0];
            for (int r = 0; r < NREG; r++) begin
                if (addr == AW'(r + 1)) begin
                    geo_p[2*r]   <= wdata[CW-1:0];
                    geo_p[2*r+1] <= wdata[HI_LSB +: CW];
                end
            end
        end
    end

    // copy pending to working bank at frame end or while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_a <= '0;
            geo_a  <= '0;
        end else if (load) begin
            ctrl_a <= ctrl_p;
            geo_a  <= geo_p;
        end
    end

    // apply the plane bit only at the vertical sync start
    always_ff @(posedge clk) begin
        if (!rst_n)
            plane_a <= 1'b0;
        else if (plane_stb)
            plane_a <= ctrl_p[CB_PLANE];
    end

    // readback words: control shows the applied plane bit
    always_comb begin
        ctrl_rb           = ctrl_p;
        ctrl_rb[CB_PLANE] = plane_a;
    end

    assign word[0] = DW'(ctrl_rb);

    for (genvar r = 0; r < NREG; r++) begin : g_word
        assign word[r+1] = (DW'(geo_p[2*r+1]) << HI_LSB) | DW'(geo_p[2*r]);
    end

    // read mux over the implemented words
    always_comb begin
        rdata = '0;
        for (int i = 0; i <= NREG; i++)
            if (addr == AW'(i))
                rdata = word[i];
    end

    // R9: plane state moves only on the sync-start strobe
    a_r9_plane_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !plane_stb |=> $stable(plane_a));

    // R10: working geometry is frozen inside a running frame
    a_r10_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_a[CB_RUN] && !frame_end) |=> ($stable(geo_a) && $stable(ctrl_a)));
endmodule

// File: rtl/dtg_count.sv
// Pixel and line counters. Assumes the totals only change when the counters
// are at zero (frame boundary or stopped). Emits frame and sync-row strobes.
module dtg_count #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] htot,
    input  logic [CW-1:0] vtot,
    input  logic [CW-1:0] vss,
    output logic [CW-1:0] h_q,
    output logic [CW-1:0] v_q,
    output logic          frame_end,
    output logic          plane_stb
);
    logic line_end;

    assign line_end  = (h_q == htot);
    assign frame_end = run && line_end && (v_q == vtot);
    assign plane_stb = run && (h_q == '0) && (v_q == vss);

    // advance column each clock and row at each line wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            h_q <= '0;
            v_q <= '0;
        end else if (line_end) begin
            h_q <= '0;
            v_q <= (v_q == vtot) ? '0 : v_q + 1'b1;
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    // R3: column never passes the line total
    a_r3_h_bound: assert property (@(posedge clk) disable iff (!rst_n)
        h_q <= htot);

    // R3: row steps by one on a mid-frame line wrap
    a_r3_v_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && line_end && v_q != vtot) |=> (v_q == CW'($past(v_q) + 1'b1)));

    // R8: stopped timing keeps both counters at zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (h_q == '0 && v_q == '0));
endmodule

// File: rtl/dtg_outgen.sv
// Output stage: decodes sync, display enable and window from the counters,
// registers them on the rising edge and optionally re-times them to the
// falling edge. Assumes the geometry inputs are the working bank.
module dtg_outgen
    import dtg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CW-1:0]             h_q,
    input  logic [CW-1:0]             v_q,
    input  logic [CTRL_W-1:0]         ctrl,
    input  logic                      plane,
    input  logic [NFIELD-1:0][CW-1:0] geo,
    output logic                      hsync,
    output logic                      vsync,
    output logic                      de,
    output logic                      win,
    output logic [CW-1:0]             pix_x,
    output logic [CW-1:0]             pix_y
);
    localparam int OW = 4 + 2 * CW;

    logic          run;
    logic          hs_raw, vs_raw, de_d, win_d;
    logic          de_p, win_p;
    logic [OW-1:0] pos_q, neg_q;
    logic          edge_q;

    assign run = ctrl[CB_RUN];

    // combinational decode of the current counter position
    always_comb begin
        hs_raw = run && (h_q >= geo[F_HSS]) &&
                 ({1'b0, h_q} < {1'b0, geo[F_HSS]} + {1'b0, geo[F_HSW]});
        vs_raw = run && (v_q >= geo[F_VSS]) &&
                 ({1'b0, v_q} < {1'b0, geo[F_VSS]} + {1'b0, geo[F_VSH]});
        de_d   = run && plane && (h_q <= geo[F_HVIS]) && (v_q <= geo[F_VVIS]);
        win_d  = run && (h_q >= geo[F_WL]) && (h_q <= geo[F_WR]) &&
                 (v_q >= geo[F_WT]) && (v_q <= geo[F_WB]);
    end

    // rising-edge output register with polarity applied
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            edge_q <= 1'b0;
        end else begin
            pos_q  <= {hs_raw ^ ctrl[CB_HINV], vs_raw ^ ctrl[CB_VINV],
                       de_d, win_d, h_q, v_q};
            edge_q <= ctrl[CB_EDGE];
        end
    end

    // falling-edge copy for the alternate output timing
    always_ff @(negedge clk) begin
        if (!rst_n)
            neg_q <= '0;
        else
            neg_q <= pos_q;
    end

    // pick the output timing selected for this pixel
    always_comb begin
        {hsync, vsync, de, win, pix_x, pix_y} = edge_q ? neg_q : pos_q;
        de_p  = pos_q[OW-3];
        win_p = pos_q[OW-4];
    end

    // R4: no display enable without the applied plane
    a_r4_plane_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !plane |=> !de_p);

    // R8: stopped timing blanks enable and window
    a_r8_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!de_p && !win_p));
endmodule

// File: rtl/disp_timing_gen.sv
// Top: register bank, counters and output stage of the raster timing
// generator. Assumes a single pixel clock domain for registers and timing.
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int CW = 12,
    parameter int AW = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          win,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y
);
    logic [CTRL_W-1:0]         ctrl_a;
    logic                      plane_a;
    logic [NFIELD-1:0][CW-1:0] geo_a;
    logic [CW-1:0]             h_q, v_q;
    logic                      frame_end, plane_stb;

    dtg_regs #(.CW(CW), .AW(AW), .DW(DW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .frame_end (frame_end),
        .plane_stb (plane_stb),
        .ctrl_a    (ctrl_a),
        .plane_a   (plane_a),
        .geo_a     (geo_a)
    );

    dtg_count #(.CW(CW)) i_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl_a[CB_RUN]),
        .htot      (geo_a[F_HTOT]),
        .vtot      (geo_a[F_VTOT]),
        .vss       (geo_a[F_VSS]),
        .h_q       (h_q),
        .v_q       (v_q),
        .frame_end (frame_end),
        .plane_stb (plane_stb)
    );

    dtg_outgen #(.CW(CW)) i_out (
        .clk   (clk),
        .rst_n (rst_n),
        .h_q   (h_q),
        .v_q   (v_q),
        .ctrl  (ctrl_a),
        .plane (plane_a),
        .geo   (geo_a),
        .hsync (hsync),
        .vsync (vsync),
        .de    (de),
        .win   (win),
        .pix_x (pix_x),
        .pix_y (pix_y)
    );
endmodule

// File: tb/test_disp_timing_gen.sv
`timescale 1ns/1ps
module test_disp_timing_gen;
    typedef struct {
        int run, hinv, vinv, edg;
        int ht, hv, hss, hsw, vt, vv, vss, vsh, wl, wt, wr, wb;
    } bcfg_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hsync, vsync, de, win;
    logic [11:0] pix_x, pix_y;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bcfg_t p, m;
    int pplane = 0, mplane = 0;
    int ex = 0, ey = 0;
    bit mon_on = 0, have_prev = 0;
    int prev_x, prev_y, early_x, early_y;

    always #4 clk = ~clk;

    disp_timing_gen i_disp_timing_gen (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync),
        .vsync(vsync), .de(de), .win(win), .pix_x(pix_x), .pix_y(pix_y)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = int'(reg_rdata);
    endtask

    task automatic wr_ctrl(input int run, input int pl, input int hi, input int vi, input int ed);
        p.run = run; p.hinv = hi; p.vinv = vi; p.edg = ed; pplane = pl;
        wr(0, run | (pl << 1) | (hi << 2) | (vi << 3) | (ed << 4));
    endtask

    task automatic wr_geo(input int a, input int hi, input int lo);
        case (a)
            1: begin p.ht = hi;  p.hv = lo;  end
            2: begin p.hsw = hi; p.hss = lo; end
            3: begin p.vt = hi;  p.vv = lo;  end
            4: begin p.vsh = hi; p.vss = lo; end
            5: begin p.wt = hi;  p.wl = lo;  end
            default: begin p.wb = hi; p.wr = lo; end
        endcase
        wr(a, (hi << 16) | lo);
    endtask

    // per-pixel monitor with an arithmetic model of the frame
    always begin
        @(posedge clk);
        #2;
        if (mon_on) begin early_x = int'(pix_x); early_y = int'(pix_y); end
        #4;
        if (mon_on) begin
            int hsr, vsr;
            chk("R3 pix_x", int'(pix_x), ex);
            chk("R3 pix_y", int'(pix_y), ey);
            chk("R4 de", int'(de), int'(mplane != 0 && ex <= m.hv && ey <= m.vv));
            hsr = int'(ex >= m.hss && ex < m.hss + m.hsw);
            vsr = int'(ey >= m.vss && ey < m.vss + m.vsh);
            if (m.hinv != 0) chk("R7 hsync", int'(hsync), 1 - hsr);
            else             chk("R5 hsync", int'(hsync), hsr);
            if (m.vinv != 0) chk("R7 vsync", int'(vsync), 1 - vsr);
            else             chk("R6 vsync", int'(vsync), vsr);
            chk("R11 win", int'(win),
                int'(ex >= m.wl && ex <= m.wr && ey >= m.wt && ey <= m.wb));
            if (have_prev) begin
                if (m.edg != 0) begin
                    chk("R12 early x", early_x, prev_x);
                    chk("R12 early y", early_y, prev_y);
                end else begin
                    chk("R12 early x", early_x, int'(pix_x));
                end
            end
            prev_x = int'(pix_x); prev_y = int'(pix_y); have_prev = 1;
            if (ex == 0 && ey == m.vss) mplane = pplane;
            if (ex == m.ht) begin
                ex = 0;
                if (ey == m.vt) begin
                    ey = 0;
                    m = p;
                    if (m.run == 0) mon_on = 0;
                end else begin
                    ey++;
                end
            end else begin
                ex++;
            end
        end
    end

    initial begin
        int d, mx;
        p = '{default: 0};
        m = '{default: 0};
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #6;
        // R1: reset state
        chk("R1 hsync", int'(hsync), 0);
        chk("R1 vsync", int'(vsync), 0);
        chk("R1 de", int'(de), 0);
        chk("R1 pix_x", int'(pix_x), 0);
        rd(0, d); chk("R1 ctrl", d, 0);
        rd(1, d); chk("R1 horz", d, 0);

        wr_geo(1, 19, 11);
        wr_geo(2, 3, 13);
        wr_geo(3, 9, 5);
        wr_geo(4, 2, 7);
        wr_geo(5, 1, 2);
        wr_geo(6, 4, 9);
        rd(1, d); chk("R2 horz", d, (19 << 16) | 11);
        rd(2, d); chk("R2 hsync", d, (3 << 16) | 13);
        rd(4, d); chk("R2 vsync", d, (2 << 16) | 7);
        rd(6, d); chk("R2 wend", d, (4 << 16) | 9);
        rd(7, d); chk("R2 unused", d, 0);

        wr_ctrl(1, 1, 0, 0, 0);
        @(posedge clk);
        @(posedge clk);
        m = p; ex = 0; ey = 0; mplane = 0; mon_on = 1;
        rd(0, d); chk("R9 plane pending", d, 1);
        wait (ey == 8);
        rd(0, d); chk("R9 plane applied", d, 3);
        repeat (600) @(posedge clk);

        // R10: mid-frame geometry and polarity change
        wait (ey == 2);
        wr_geo(1, 23, 15);
        wr_geo(2, 4, 17);
        wr_geo(6, 4, 12);
        wr_ctrl(1, 1, 1, 0, 0);
        rd(1, d); chk("R2 horz new", d, (23 << 16) | 15);
        mx = 0;
        do begin
            @(posedge clk); #6;
            if (int'(pix_x) > mx) mx = int'(pix_x);
        end while (!(pix_x == 0 && pix_y == 0));
        chk("R10 old line length", mx, 19);
        mx = 0;
        do begin
            @(posedge clk); #6;
            if (int'(pix_x) > mx) mx = int'(pix_x);
        end while (!(pix_x == 0 && pix_y == 0));
        chk("R10 new line length", mx, 23);

        // R12: falling-edge output timing
        wait (ey == 2);
        wr_ctrl(1, 1, 1, 1, 1);
        repeat (500) @(posedge clk);

        // R9: plane off held until the sync row
        wait (ey == 2);
        wr_ctrl(1, 0, 1, 1, 1);
        rd(0, d); chk("R9 plane still on", d & 2, 2);
        wait (ey == 8);
        rd(0, d); chk("R9 plane now off", d & 2, 0);
        repeat (500) @(posedge clk);

        // R8: stop timing with inverted syncs
        wait (ey == 2);
        wr_ctrl(0, 0, 1, 1, 0);
        wait (mon_on == 0);
        repeat (20) @(posedge clk);
        #6;
        chk("R8 pix_x", int'(pix_x), 0);
        chk("R8 pix_y", int'(pix_y), 0);
        chk("R8 de", int'(de), 0);
        chk("R8 win", int'(win), 0);
        chk("R8 hsync idle", int'(hsync), 1);
        chk("R8 vsync idle", int'(vsync), 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule